// File: doc/BRIEF.md
# Debounced Status Interrupt Controller

This block turns three raw status levels into one active-low interrupt line. Each level first passes through its own debounce counter, which accepts a new level only after it has held unchanged for a programmable number of clock cycles. A bounce inside that window throws away the count gathered so far. Each debounced level then feeds an event detector, and the events latch into a set of sticky pending bits.

Source 0 is a supply-comparator level, and either direction of change counts as an event. Source 1 is a dead-battery-mode flag and source 2 is a contact-timeout flag; for these two, only a 0-to-1 change counts. The interrupt line is low whenever the global enable is high and at least one pending bit is set. Clearing the enable masks the line but keeps the pending bits. The pending bits clear only on a read strobe of the interrupt register. An event that lands in the same cycle as the read survives that read.

Top module: `stat_irq_ctrl`

## Requirements
- R1: After synchronous reset, every pending bit is 0 and `irq_n` is 1.
- R2: On source 0 (bit 0), both a 0-to-1 and a 1-to-0 change of the debounced level set pending bit 0.
- R3: On sources 1 and 2 (bits 1 and 2), only a 0-to-1 change of the debounced level sets the pending bit; a 1-to-0 change leaves `pend` unchanged.
- R4: A raw level must differ from the debounced level for `DB_CYC` consecutive rising edges before it is accepted. The pending bit appears after edge `DB_CYC+1` counted from the first edge that samples the new level, and not after edge `DB_CYC`.
- R5: A raw level that returns to the debounced value before `DB_CYC` edges raises no event, and the count restarts from zero.
- R6: `irq_n` is 0 exactly when `irq_en` is 1 and at least one pending bit is 1.
- R7: While `irq_en` is 0, `irq_n` stays 1 and new events still set pending bits.
- R8: A rising edge with `irq_rd` high clears every pending bit whose event is not arriving in that same cycle.
- R9: An event arriving in the same cycle as `irq_rd` leaves its pending bit set after the read.
- R10: Raising `irq_en` while bits are pending drives `irq_n` low in the same cycle, with no clock edge needed.
- R11: Without a read, pending bits stay set indefinitely, and events from several sources accumulate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_stat | input | NSRC | Raw status levels; bit 0 supply comparator, bit 1 dead-battery mode, bit 2 contact timeout |
| irq_en | input | 1 | Global interrupt enable |
| irq_rd | input | 1 | Read strobe of the interrupt register; clears pending bits |
| pend | output | NSRC | Latched pending event bits |
| irq_n | output | 1 | Interrupt output, active low |

## Verification
The bench builds the block with `DB_CYC = 8` and the default three sources with only bit 0 on any-edge triggering. A window of eight cycles puts the exact acceptance edge within reach: the bench samples `pend` one edge before and one edge after acceptance. It also makes a bounce of seven cycles, which stays one short of the window, followed by a full-length hold. The default 30 ms window at the design clock would take millions of cycles per event, so the short window is what makes read-versus-event collisions and masking sequences practical to drive.

// File: rtl/stat_irq_pkg.sv
package stat_irq_pkg;

    // How a debounced level produces an event
    typedef enum logic {
        TRIG_ANY  = 1'b0,
        TRIG_RISE = 1'b1
    } trig_e;

    // Debounced level and its event, carried per source
    typedef struct packed {
        logic lvl;
        logic evt;
    } src_stat_t;

    function automatic trig_e trig_for(input int idx, input logic [31:0] any_mask);
        return any_mask[idx] ? TRIG_ANY : TRIG_RISE;
    endfunction

    function automatic int cnt_width(input int cycles);
        return (cycles < 2) ? 1 : $clog2(cycles + 1);
    endfunction

endpackage

// File: rtl/stat_debounce.sv
module stat_debounce #(
    parameter int DB_CYC = 7_500_000
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic lvl
);
    import stat_irq_pkg::*;

    localparam int CW = cnt_width(DB_CYC);
    localparam logic [CW-1:0] LAST = CW'(DB_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl <= 1'b0;
            cnt <= '0;
        end else if (raw == lvl) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            lvl <= raw;
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R5: the filtered level only moves to a value the raw input held
    a_r5_lvl_follows_raw: assert property (@(posedge clk) disable iff (rst)
        !$stable(lvl) |-> ($past(raw) == lvl));

    // R4: the hold counter never passes the window
    a_r4_cnt_in_window: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

endmodule

// File: rtl/stat_edge.sv
module stat_edge
    import stat_irq_pkg::*;
#(
    parameter trig_e TRIG = TRIG_RISE
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      lvl,
    output src_stat_t st
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl;
    end

    generate
        if (TRIG == TRIG_ANY) begin : g_any
            always_comb st.evt = lvl ^ lvl_q;
        end else begin : g_rise
            always_comb st.evt = lvl & ~lvl_q;
        end
    endgenerate

    always_comb st.lvl = lvl;

endmodule

// File: rtl/stat_pend_reg.sv
module stat_pend_reg #(
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] evt,
    input  logic            irq_rd,
    output logic [NSRC-1:0] pend
);
    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (irq_rd ? '0 : pend) | evt;
    end

    // R8: a read with no arriving event empties the register
    a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
        (irq_rd && evt == '0) |=> (pend == '0));

    // R9: any arriving event is latched, read or not
    a_r9_event_kept: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> ((pend & $past(evt)) == $past(evt)));

    // R11: without a read no pending bit drops
    a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
        !irq_rd |=> ((pend & $past(pend)) == $past(pend)));

endmodule

// File: rtl/stat_irq_ctrl.sv
module stat_irq_ctrl
    import stat_irq_pkg::*;
#(
    parameter int              NSRC     = 3,
    parameter int              DB_CYC   = 7_500_000,
    parameter logic [NSRC-1:0] ANY_MASK = NSRC'(1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] raw_stat,
    input  logic            irq_en,
    input  logic            irq_rd,
    output logic [NSRC-1:0] pend,
    output logic            irq_n
);
    src_stat_t [NSRC-1:0] st;
    logic      [NSRC-1:0] dbn;
    logic      [NSRC-1:0] evt;

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_src
            localparam trig_e T = trig_for(i, 32'(ANY_MASK));

            stat_debounce #(.DB_CYC(DB_CYC)) u_db (
                .clk (clk),
                .rst (rst),
                .raw (raw_stat[i]),
                .lvl (dbn[i])
            );

            stat_edge #(.TRIG(T)) u_edge (
                .clk (clk),
                .rst (rst),
                .lvl (dbn[i]),
                .st  (st[i])
            );

            always_comb evt[i] = st[i].evt;

            if (T == TRIG_RISE) begin : g_chk_rise
                // R3: a rise-only bit is newly pending only after its level went high
                a_r3_rise_only: assert property (@(posedge clk) disable iff (rst)
                    ($rose(pend[i]) && !$past(irq_rd)) |-> $past(dbn[i]));
            end else begin : g_chk_any
                // R2: an any-edge bit is newly pending only after its level moved
                a_r2_any_edge: assert property (@(posedge clk) disable iff (rst)
                    ($rose(pend[i]) && !$past(irq_rd)) |-> ($past(dbn[i]) != $past(dbn[i], 2)));
            end
        end
    endgenerate

    stat_pend_reg #(.NSRC(NSRC)) u_pend (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .irq_rd (irq_rd),
        .pend   (pend)
    );

    always_comb irq_n = ~(irq_en & (|pend));

endmodule

// File: tb/stat_irq_ctrl_test.sv
module stat_irq_ctrl_test;
    localparam int D = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] raw_stat = '0;
    logic       irq_en = 1'b0;
    logic       irq_rd = 1'b0;
    logic [2:0] pend;
    logic       irq_n;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    stat_irq_ctrl #(.NSRC(3), .DB_CYC(D), .ANY_MASK(3'b001)) uut (
        .clk(clk), .rst(rst), .raw_stat(raw_stat), .irq_en(irq_en),
        .irq_rd(irq_rd), .pend(pend), .irq_n(irq_n)
    );

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_read();
        irq_rd = 1'b1;
        tick(1);
        irq_rd = 1'b0;
    endtask

    task automatic t_reset();
        tick(3);
        rst = 1'b0;
        tick(1);
        check("R1 pend", pend, 0);
        check("R1 irq_n", irq_n, 1);
    endtask

    task automatic t_supply_edges();
        irq_en = 1'b1;
        raw_stat[0] = 1'b1;
        tick(D);
        check("R4 not before window", pend, 0);
        tick(1);
        check("R2 rise pend", pend, 3'b001);
        check("R6 irq_n low", irq_n, 0);
        do_read();
        check("R8 cleared", pend, 0);
        check("R6 irq_n high", irq_n, 1);
        raw_stat[0] = 1'b0;
        tick(D + 1);
        check("R2 fall pend", pend, 3'b001);
        do_read();
    endtask

    task automatic t_rise_only();
        raw_stat[1] = 1'b1;
        tick(D + 1);
        check("R3 src1 rise", pend, 3'b010);
        do_read();
        raw_stat[1] = 1'b0;
        tick(D + 3);
        check("R3 src1 fall ignored", pend, 0);
        raw_stat[2] = 1'b1;
        tick(D + 1);
        check("R3 src2 rise", pend, 3'b100);
        do_read();
        raw_stat[2] = 1'b0;
        tick(D + 3);
        check("R3 src2 fall ignored", pend, 0);
    endtask

    task automatic t_bounce();
        raw_stat[2] = 1'b1;
        tick(D - 1);
        raw_stat[2] = 1'b0;
        tick(1);
        raw_stat[2] = 1'b1;
        tick(D - 1);
        check("R5 bounce restarts", pend, 0);
        tick(2);
        check("R5 full hold accepted", pend, 3'b100);
        do_read();
        raw_stat[2] = 1'b0;
        tick(D + 1);
        check("R3 src2 fall ignored again", pend, 0);
    endtask

    task automatic t_mask();
        irq_en = 1'b0;
        raw_stat[1] = 1'b1;
        tick(D + 1);
        check("R7 pending while masked", pend, 3'b010);
        check("R7 irq_n masked", irq_n, 1);
        tick(20);
        check("R11 sticky", pend, 3'b010);
        raw_stat[0] = 1'b1;
        tick(D + 1);
        check("R11 accumulate", pend, 3'b011);
        check("R7 still masked", irq_n, 1);
        @(negedge clk);
        irq_en = 1'b1;
        #0.5;
        check("R10 immediate assert", irq_n, 0);
        tick(1);
        do_read();
        check("R8 clear after unmask", pend, 0);
        check("R6 released", irq_n, 1);
    endtask

    task automatic t_collide();
        raw_stat[0] = 1'b0;
        tick(D + 1);
        check("R2 fall sets", pend, 3'b001);
        raw_stat[1] = 1'b0;
        tick(D + 1);
        check("R3 fall no change", pend, 3'b001);
        raw_stat[1] = 1'b1;
        tick(D);
        irq_rd = 1'b1;
        tick(1);
        irq_rd = 1'b0;
        check("R9 event survives read", pend, 3'b010);
        check("R6 irq_n low after collide", irq_n, 0);
        do_read();
        check("R8 final clear", pend, 0);
    endtask

    initial begin
        t_reset();
        t_supply_edges();
        t_rise_only();
        t_bounce();
        t_mask();
        t_collide();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule